// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds a bank of eight-bit configuration registers for the clock-control logic around it. A host changes the bank with a block write and reads it back with a block read. The bus runs in standard mode at up to 100 kbit/s. The SCL and SDA pins are sampled with the system clock. The block drives SDA through an open-drain pull-low enable. Every register is also presented in parallel on `cfg_o`, so neighbouring logic sees it directly.

A write frame has a fixed layout. It starts with the write address, then a command byte and a count byte. Both are acknowledged and their values are thrown away. The data bytes that follow fill the registers upward from register 0. The host may stop after any whole byte. A read frame returns a count byte first and then the readable registers in ascending order. On readback, some bits are replaced by inverted strap levels that come from outside.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, `cfg_o` holds register 0 = 0x00, registers 1 to 4 = 0xFF, register 5 = 0x06 and register 6 = 0xFF, and SDA is released.
- R2: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). For any other address byte it does not acknowledge, and it stays silent on every following byte until the next START.
- R3: In a write, the two bytes after the address are acknowledged and change no register.
- R4: Data bytes are stored one per byte, starting at register 0 and going upward. Data bytes beyond register 6 are acknowledged and dropped.
- R5: A STOP after any complete byte ends the write. Registers already written keep their new values and all others stay unchanged.
- R6: The slave acknowledges every byte it accepts by holding SDA low while SCL is high in the ninth clock.
- R7: A read returns the count value 6 first, then registers 0 through 5, each most significant bit first.
- R8: On readback, register 1 bits [7:5] show `strap_inv_i[2:0]` and register 4 bit 1 shows `strap_inv_i[3]`. The stored values and `cfg_o` are not affected.
- R9: While transmitting, the slave changes SDA only while SCL is low. After the host does not acknowledge a byte, the slave releases SDA, so further clocks read all ones.
- R10: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START in the middle of a frame abandons that frame and begins address decoding again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_inv_i | input | 4 | Inverted strap levels shown on readback |
| sda_pull_o | output | 1 | Drive SDA low when 1 |
| cfg_o | output | NUM_REGS*8 | Register bank, register n at bits [8n+7:8n] |

## Verification
The bench builds the block with its default parameters: seven registers, six readable bytes, address 0x69 and two-stage synchronizers. With seven registers, a ten-byte write runs past the end of the bank, so the dropping of surplus data can be observed. With six readable bytes, a full read ends just before the last register. The bus is driven with a 20-cycle half period. This leaves room for the synchronizer delay, and for a monitor that checks that every change of the pull-low enable falls while SCL is low.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WRX,
    ST_WRX_ACK,
    ST_TX,
    ST_TX_HACK
  } link_state_e;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h00;
      5:       return 8'h06;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int LINES = 2;  // index 1 = scl, 0 = sda

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign lvl[g] = chain[STAGES-1];
  end

  assign scl_o      = lvl[1];
  assign sda_o      = lvl[0];
  assign scl_rise_o = lvl[1] & ~prev[1];
  assign scl_fall_o = ~lvl[1] & prev[1];
  assign start_o    = lvl[1] & prev[1] & prev[0] & ~lvl[0];
  assign stop_o     = lvl[1] & prev[1] & ~prev[0] & lvl[0];

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int STRAP_W  = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  input  logic [STRAP_W-1:0]    strap_inv_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int STRAP_REG_A = 1;  // bits [7:5] <- strap[2:0]
  localparam int STRAP_REG_B = 4;  // bit 1 <- strap[3]

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[g*8 +: 8] <= reg_default(g);
      else if (wr_en_i && wr_idx_i == IDX_W'(g))
        regs_o[g*8 +: 8] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = 8'hFF;
    if (int'(rd_idx_i) < NUM_REGS) rd_data_o = regs_o[rd_idx_i*8 +: 8];
    if (rd_idx_i == IDX_W'(STRAP_REG_A)) rd_data_o[7:5] = strap_inv_i[2:0];
    if (rd_idx_i == IDX_W'(STRAP_REG_B)) rd_data_o[1]   = strap_inv_i[3];
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> int'(wr_idx_i) < NUM_REGS); // R4
  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_o[$past(wr_idx_i)*8 +: 8] == $past(wr_data_i)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(regs_o)); // R5

endmodule

// File: rtl/cfg_link_fsm.sv
module cfg_link_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int          NUM_REGS   = 7,
  parameter int          READ_BYTES = 6,
  parameter logic [6:0]  DEV_ADDR   = 7'h69,
  localparam int         IDX_W      = $clog2(NUM_REGS),
  localparam int         CNT_W      = $clog2(NUM_REGS + 3),
  localparam int         TX_W       = $clog2(READ_BYTES + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic             sda_pull_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [IDX_W-1:0] rd_idx_o
);

  localparam int CNT_SAT = NUM_REGS + 2;  // two dummy bytes + registers
  localparam int TX_SAT  = READ_BYTES + 1;

  link_state_e      state;
  logic [7:0]       shreg;
  logic [3:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [TX_W-1:0]  tx_idx;
  logic             is_read;
  logic             nack;
  logic [7:0]       tx_src;

  assign rd_idx_o = IDX_W'(tx_idx - TX_W'(1));

  always_comb begin
    if (tx_idx == '0)                       tx_src = 8'(READ_BYTES);
    else if (int'(tx_idx) <= READ_BYTES)    tx_src = rd_data_i;
    else                                    tx_src = 8'hFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bit_cnt    <= '0;
      byte_cnt   <= '0;
      tx_idx     <= '0;
      is_read    <= 1'b0;
      nack       <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state      <= ST_ADDR;
        bit_cnt    <= '0;
        byte_cnt   <= '0;
        tx_idx     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WRX: begin
            if (scl_rise_i) begin
              shreg   <= {shreg[6:0], sda_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall_i && bit_cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_pull_o <= 1'b1;
                  is_read    <= shreg[0];
                  state      <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_pull_o <= 1'b1;
                state      <= ST_WRX_ACK;
                if (int'(byte_cnt) >= 2 && int'(byte_cnt) < CNT_SAT) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= IDX_W'(byte_cnt - CNT_W'(2));
                  wr_data_o <= shreg;
                end
                if (int'(byte_cnt) != CNT_SAT) byte_cnt <= byte_cnt + CNT_W'(1);
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              bit_cnt <= '0;
              if (is_read) begin
                shreg      <= tx_src;
                sda_pull_o <= ~tx_src[7];
                tx_idx     <= tx_idx + TX_W'(1);
                state      <= ST_TX;
              end else begin
                sda_pull_o <= 1'b0;
                state      <= ST_WRX;
              end
            end
          end
          ST_WRX_ACK: begin
            if (scl_fall_i) begin
              sda_pull_o <= 1'b0;
              bit_cnt    <= '0;
              state      <= ST_WRX;
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_cnt == 4'd8) begin
                sda_pull_o <= 1'b0;
                bit_cnt    <= '0;
                state      <= ST_TX_HACK;
              end else begin
                shreg      <= {shreg[6:0], 1'b0};
                sda_pull_o <= ~shreg[6];
              end
            end
          end
          ST_TX_HACK: begin
            if (scl_rise_i) begin
              nack <= sda_i;
            end else if (scl_fall_i) begin
              if (nack) begin
                sda_pull_o <= 1'b0;
                state      <= ST_IDLE;
              end else begin
                shreg      <= tx_src;
                sda_pull_o <= ~tx_src[7];
                if (int'(tx_idx) != TX_SAT) tx_idx <= tx_idx + TX_W'(1);
                state      <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !$past(scl_i)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_pull_o); // R2
  AST_ACK_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WRX_ACK || state == ST_ADDR_ACK) |-> sda_pull_o); // R6
  AST_TX_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_TX |-> is_read); // R7

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         NUM_REGS    = 7,
  parameter int         READ_BYTES  = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [3:0]            strap_inv_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic             scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  cfg_link_fsm #(
    .NUM_REGS   (NUM_REGS),
    .READ_BYTES (READ_BYTES),
    .DEV_ADDR   (DEV_ADDR)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .rd_data_i  (rd_data),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_idx_o   (rd_idx)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .STRAP_W(4)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .rd_idx_i    (rd_idx),
    .strap_inv_i (strap_inv_i),
    .rd_data_o   (rd_data),
    .regs_o      (cfg_o)
  );

endmodule

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb_top;

  localparam int NREG = 7;
  localparam int H    = 20;

  typedef struct {
    int    val;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic [3:0] strap = 4'b0000;
  logic sda_pull;
  logic [NREG*8-1:0] cfg;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t exp_q[$];
  int    obs_q[$];
  logic [7:0] model [NREG];

  always #5 clk = ~clk;

  assign sda_line = sda_h & ~sda_pull;

  cfg_i2c_slave dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_h),
    .sda_i       (sda_line),
    .strap_inv_i (strap),
    .sda_pull_o  (sda_pull),
    .cfg_o       (cfg)
  );

  // scoreboard monitor
  initial forever begin
    wait (obs_q.size() > 0);
    begin
      item_t e;
      int o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      checks++;
      if (o != e.val) begin
        errors++;
        $display("FAIL %s: got %0h expected %0h", e.tag, o, e.val);
      end
    end
  end

  // R9: slave output moves only with SCL low
  always @(sda_pull) begin
    if (rst_n && !done) begin
      checks++;
      if (scl_h !== 1'b0) begin
        errors++;
        $display("FAIL R9: pull changed with scl=%0b expected 0", scl_h);
      end
    end
  end

  task automatic expect_item(input int v, input string tag, input int got);
    item_t it;
    it.val = v;
    it.tag = tag;
    exp_q.push_back(it);
    obs_q.push_back(got);
    #1;
  endtask

  function automatic logic [7:0] rd_model(input int i);
    logic [7:0] v;
    v = model[i];
    if (i == 1) v[7:5] = strap[2:0];
    if (i == 4) v[1] = strap[3];
    return v;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_h = 1'b1; hold(H/2);
    scl_h = 1'b1; hold(H/2);
    sda_h = 1'b0; hold(H/2);
    scl_h = 1'b0; hold(H/2);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; hold(H/2);
    scl_h = 1'b1; hold(H/2);
    sda_h = 1'b1; hold(H);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_h = b;    hold(H/2);
    scl_h = 1'b1; hold(H/2);
    s = sda_line; hold(H/2);
    scl_h = 1'b0; hold(H/2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack_n);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, ack_n);
  endtask

  task automatic recv_byte(input logic host_nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(1'b1, d[i]);
    clk_bit(host_nack, s);
  endtask

  task automatic check_cfg(input string tag);
    for (int i = 0; i < NREG; i++) expect_item(model[i], tag, cfg[i*8 +: 8]);
  endtask

  task automatic write_frame(input logic [7:0] data [], input string tag);
    logic a;
    bus_start();
    send_byte(8'hD2, a);  expect_item(0, "R2 write addr ack", a);
    send_byte(8'hC3, a);  expect_item(0, "R3 command ack", a);
    send_byte(8'h5A, a);  expect_item(0, "R3 count ack", a);
    foreach (data[k]) begin
      send_byte(data[k], a);
      expect_item(0, "R6 data ack", a);
      if (k < NREG) model[k] = data[k];
    end
    bus_stop();
    check_cfg(tag);
  endtask

  task automatic read_frame(input int nbytes);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD3, a);  expect_item(0, "R2 read addr ack", a);
    recv_byte(1'b0, d);   expect_item(6, "R7 count byte", d);
    for (int i = 0; i < nbytes; i++) begin
      recv_byte(i == nbytes - 1, d);
      expect_item(rd_model(i), "R7 R8 read data", d);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h00 : (i == 5) ? 8'h06 : 8'hFF;
    hold(4);
    rst_n = 1'b1;
    hold(4);

    // R1 reset state
    check_cfg("R1 defaults");
    expect_item(0, "R1 sda released", sda_pull);

    // R3 R4 R5: two data bytes then stop
    write_frame('{8'h3C, 8'hA5}, "R5 partial write");

    // R2: foreign address ignored, later bytes also not acked
    bus_start();
    send_byte(8'hA0, a); expect_item(1, "R2 foreign addr nack", a);
    send_byte(8'h77, a); expect_item(1, "R2 silent after nack", a);
    bus_stop();
    check_cfg("R2 no change");

    // R4: overrun past last register
    write_frame('{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17, 8'h18, 8'h19},
                "R4 overrun write");

    // R7 R8: full read with straps
    strap = 4'b1010;
    read_frame(6);
    check_cfg("R8 cfg unaffected");

    // R5: single byte rewrite
    write_frame('{8'h9E}, "R5 single byte");

    // R9: host nacks first data byte, slave then releases
    bus_start();
    send_byte(8'hD3, a);  expect_item(0, "R2 read addr ack", a);
    recv_byte(1'b0, d);   expect_item(6, "R7 count byte", d);
    recv_byte(1'b1, d);   expect_item(rd_model(0), "R7 byte0", d);
    recv_byte(1'b1, d);   expect_item(8'hFF, "R9 released after nack", d);
    bus_stop();

    // R10: START mid-frame restarts decoding
    bus_start();
    send_byte(8'hD2, a); expect_item(0, "R10 addr ack", a);
    send_byte(8'h00, a); expect_item(0, "R3 command ack", a);
    send_byte(8'h00, a); expect_item(0, "R3 count ack", a);
    send_byte(8'h42, a); expect_item(0, "R10 data ack", a);
    model[0] = 8'h42;
    bus_start();
    send_byte(8'hD3, a);  expect_item(0, "R10 restart read ack", a);
    recv_byte(1'b0, d);   expect_item(6, "R10 count", d);
    recv_byte(1'b0, d);   expect_item(8'h42, "R10 byte0 after restart", d);
    recv_byte(1'b1, d);   expect_item(rd_model(1), "R10 byte1", d);
    bus_stop();
    check_cfg("R10 cfg");

    wait (obs_q.size() == 0);
    hold(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule